// File: doc/BRIEF.md
# External Status Change Latch

This block watches a group of status conditions that belong to one serial channel. Examples are line levels, carrier and clear-to-send style signals, and a break/abort detector. While the block is armed, its status output follows the inputs one cycle late. When any condition changes, the block sets a change flag and freezes a copy of every condition as it stood in that cycle. From then on, further input activity is ignored until the host issues a rearm strobe.

The rearm strobe clears the flag and takes the live inputs as the new baseline. Change detection starts again from the following cycle. The interrupt output is the change flag gated by an enable bit. The break/abort condition is watched like the others, so both its onset and its end raise an interrupt. The host can therefore time the break and close or reopen a message around it.

The inputs are assumed to be already synchronised to `clk`. The first cycle after reset only loads the baseline, so inputs that are active at start-up raise no interrupt.

Top module: `ext_status_latch`

## Requirements
- R1: During reset, `stat_out` is 0 and `irq` is 0. On the first clock edge after reset, `stat_out` loads the input values and no interrupt is raised.
- R2: While armed, if `stat_in` differs from the value it had in the previous cycle, the flag is set on that edge and `irq` rises on the same edge. At that edge, `stat_out` holds all five input bits as they stood in that cycle.
- R3: While the flag is set and no rearm is given, `stat_out` and `irq` stay unchanged, whatever the inputs do.
- R4: While armed and the inputs are steady, `stat_out` equals the inputs of the previous cycle and `irq` stays 0.
- R5: A rearm pulse of one cycle on `rearm` clears `irq` on the next edge. On that same edge, `stat_out` loads the inputs present during the pulse.
- R6: `irq` is the flag ANDed with `irq_en`, registered. With `irq_en` low, a change still freezes `stat_out` and `irq` stays 0. Raising `irq_en` while the flag is set drives `irq` high on the next edge.
- R7: Bit 4 of `stat_in` is break/abort detect. Both its rising edge and its falling edge raise an interrupt.
- R8: An input change in the same cycle as a rearm pulse becomes part of the new baseline and raises no interrupt.
- R9: A change on several bits in one cycle sets the flag once and captures all of those bits together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_in | input | 5 | Live status conditions; bit 4 is break/abort |
| rearm | input | 1 | Rearm strobe: clears the flag and reloads the baseline |
| irq_en | input | 1 | Interrupt enable |
| stat_out | output | 5 | Registered status view, frozen while the flag is set |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its default parameters: five conditions, with break/abort on bit 4. With these values, every condition can be toggled on its own, several can change together, and the break bit can be driven through both of its edges. The tests target the cycle in which the flag sets against the cycle in which `stat_out` freezes. They also cover a rearm that coincides with an input change, and an enable that rises after the flag has already been set.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam int unsigned NUM_COND = 5;
  localparam int unsigned BRK_BIT  = 4;
  typedef logic [NUM_COND-1:0] cond_t;
endpackage

// File: rtl/esl_diff.sv
module esl_diff #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] base,
  output logic [W-1:0] delta,
  output logic         any
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign delta[i] = cur[i] ^ base[i];
  end
  assign any = |delta;
endmodule

// File: rtl/esl_core.sv
module esl_core #(
  parameter int unsigned W   = 5,
  parameter int unsigned BRK = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_in,
  input  logic         rearm,
  input  logic         irq_en,
  input  logic         change,
  output logic [W-1:0] snap,
  output logic         latched,
  output logic         irq
);
  logic         primed;
  logic         latch_d;
  logic [W-1:0] snap_d;

  always_comb begin
    latch_d = latched;
    snap_d  = snap;
    if (!primed) begin
      snap_d = stat_in;
    end else if (rearm) begin
      latch_d = 1'b0;
      snap_d  = stat_in;
    end else if (!latched) begin
      snap_d = stat_in;
      if (change) latch_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed  <= 1'b0;
      latched <= 1'b0;
      snap    <= '0;
      irq     <= 1'b0;
    end else begin
      primed  <= 1'b1;
      latched <= latch_d;
      snap    <= snap_d;
      irq     <= latch_d & irq_en;
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (primed && !latched && !rearm && (stat_in != snap)) |=> (latched && snap == $past(stat_in)));
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (latched && !rearm) |=> ($stable(snap) && latched));
  assert_track_R4: assert property (@(posedge clk) disable iff (rst)
    (primed && !latched && !rearm && (stat_in == snap)) |=> (!latched && !irq));
  assert_rearm_R5: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (!latched && !irq && snap == $past(stat_in)));
  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    irq |-> latched);
  assert_break_R7: assert property (@(posedge clk) disable iff (rst)
    (primed && !latched && !rearm && (stat_in[BRK] != snap[BRK])) |=> latched);
endmodule

// File: rtl/ext_status_latch.sv
module ext_status_latch
  import esl_pkg::*;
#(
  parameter int unsigned W   = NUM_COND,
  parameter int unsigned BRK = BRK_BIT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_in,
  input  logic         rearm,
  input  logic         irq_en,
  output logic [W-1:0] stat_out,
  output logic         irq
);
  logic [W-1:0] snap;
  logic [W-1:0] delta;
  logic         any_chg;
  logic         latched;

  esl_diff #(.W(W)) u_diff (
    .cur   (stat_in),
    .base  (snap),
    .delta (delta),
    .any   (any_chg)
  );

  esl_core #(.W(W), .BRK(BRK)) u_core (
    .clk     (clk),
    .rst     (rst),
    .stat_in (stat_in),
    .rearm   (rearm),
    .irq_en  (irq_en),
    .change  (any_chg),
    .snap    (snap),
    .latched (latched),
    .irq     (irq)
  );

  assign stat_out = snap;

  assert_reset_R1: assert property (@(posedge clk) rst |=> (stat_out == '0 && !irq));
endmodule

// File: tb/tb_ext_status_latch.sv
module tb_ext_status_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] stat_in = '0;
  logic       rearm = 1'b0;
  logic       irq_en = 1'b1;
  logic [4:0] stat_out;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_status_latch dut (
    .clk(clk), .rst(rst), .stat_in(stat_in), .rearm(rearm),
    .irq_en(irq_en), .stat_out(stat_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_rearm(input logic [4:0] v);
    stat_in = v; rearm = 1'b1;
    tick();
    rearm = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; stat_in = 5'b00101;
    tick(); tick();
    chk("R1 stat_out in reset", stat_out, 5'b0);
    chk("R1 irq in reset", {4'b0, irq}, 5'b0);
    rst = 1'b0;
    tick();
    chk("R1 baseline loaded", stat_out, 5'b00101);
    chk("R1 no irq on baseline", {4'b0, irq}, 5'b0);
  endtask

  task automatic t_track;
    tick();
    chk("R4 steady stat_out", stat_out, 5'b00101);
    chk("R4 steady irq", {4'b0, irq}, 5'b0);
  endtask

  task automatic t_capture_hold;
    stat_in = 5'b00111;
    tick();
    chk("R2 irq on change", {4'b0, irq}, 5'b1);
    chk("R2 snapshot", stat_out, 5'b00111);
    stat_in = 5'b01000; tick();
    stat_in = 5'b11010; tick();
    chk("R3 frozen stat_out", stat_out, 5'b00111);
    chk("R3 irq held", {4'b0, irq}, 5'b1);
  endtask

  task automatic t_rearm;
    do_rearm(5'b11010);
    chk("R5 irq cleared", {4'b0, irq}, 5'b0);
    chk("R5 baseline reload", stat_out, 5'b11010);
    tick();
    chk("R5 no irq after rearm", {4'b0, irq}, 5'b0);
  endtask

  task automatic t_same_cycle;
    do_rearm(5'b11011);
    chk("R8 new value as baseline", stat_out, 5'b11011);
    tick();
    chk("R8 no irq for coincident change", {4'b0, irq}, 5'b0);
  endtask

  task automatic t_break;
    do_rearm(5'b00000); tick();
    stat_in = 5'b10000; tick();
    chk("R7 break onset irq", {4'b0, irq}, 5'b1);
    chk("R7 break onset snapshot", stat_out, 5'b10000);
    do_rearm(5'b10000); tick();
    chk("R7 no irq while break steady", {4'b0, irq}, 5'b0);
    stat_in = 5'b00000; tick();
    chk("R7 break end irq", {4'b0, irq}, 5'b1);
    chk("R7 break end snapshot", stat_out, 5'b00000);
  endtask

  task automatic t_enable;
    do_rearm(5'b00000);
    irq_en = 1'b0; tick();
    stat_in = 5'b00010; tick();
    chk("R6 irq gated off", {4'b0, irq}, 5'b0);
    stat_in = 5'b00100; tick();
    chk("R6 snapshot frozen while gated", stat_out, 5'b00010);
    irq_en = 1'b1; tick();
    chk("R6 irq after enable", {4'b0, irq}, 5'b1);
  endtask

  task automatic t_multi;
    do_rearm(5'b00100); tick();
    stat_in = 5'b01011; tick();
    chk("R9 multi-bit snapshot", stat_out, 5'b01011);
    chk("R9 multi-bit irq", {4'b0, irq}, 5'b1);
    stat_in = 5'b00000; tick();
    chk("R9 held after multi", stat_out, 5'b01011);
  endtask

  initial begin
    t_reset();
    t_track();
    t_capture_hold();
    t_rearm();
    t_same_cycle();
    t_break();
    t_enable();
    t_multi();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule